// File: doc/BRIEF.md
# Command/Address Parity Guard with Alert

This block sits on the receive side of a DRAM command/address bus. On every rising clock edge where chip select is asserted (low), it checks even parity over the command and address inputs against a separate parity input. A clean command goes to a registered downstream command port. A command that fails the check is suppressed, and an active-low alert output is driven low for a programmable recovery interval. Every command that arrives during that interval is also dropped.

A second, independent source drives the same alert pin: a one-cycle write-data CRC error strobe. It produces an alert pulse of programmable width that ends on its own. A parity error takes priority over a running CRC pulse. For readout, the block keeps a sticky parity-error flag and a copy of the first failing command, and a clear strobe resets both. The check enable, the recovery length and the pulse width are plain inputs, expressed in clock cycles.

Top module: `ca_parity_guard`

## Requirements
- R1: While reset is low, and after it is released, the block has `alert_n` = 1, `out_valid` = 0, `err_flag` = 0 and all captured error fields at 0.
- R2: A command is sampled only on a rising edge where `cs_n` = 0. It is accepted when the XOR of `act_n`, `addr[16:0]`, `bg`, `ba` and `par_in` is 0. On the following cycle it appears on `out_valid`/`out_*` with its fields unchanged. A cycle with `cs_n` = 1 forwards nothing and raises no error, whatever its parity.
- R3: With `par_en` = 1, a command whose XOR is 1 is not forwarded (`out_valid` stays 0 on the next cycle).
- R4: A parity error drives `alert_n` low from the cycle after the failing edge. It stays low for exactly `recov_cycles` cycles, where a value of 0 counts as 1, and then returns high.
- R5: Every command that arrives while the recovery interval runs is dropped. This includes commands with bad parity, which neither restart the interval nor update the captured fields. The first command after `alert_n` returns high is accepted.
- R6: With `par_en` = 0, a command with bad parity is forwarded, `alert_n` stays high and `err_flag` stays 0.
- R7: A `crc_err` strobe sampled outside recovery drives `alert_n` low from the next cycle for `crc_cycles` cycles, where 0 counts as 1. A new strobe during the pulse restarts the full width.
- R8: A parity error cancels a running CRC pulse, so `alert_n` then follows the recovery length alone. A `crc_err` strobe sampled during recovery is ignored.
- R9: `err_flag` is set by an accepted parity error and holds until `clr` is sampled high. If `clr` and a parity error arrive on the same edge, the flag ends up set.
- R10: `err_act_n`, `err_addr`, `err_bg` and `err_ba` hold the first failing command since the last clear. Later errors do not overwrite them while `err_flag` is set. `clr` alone zeroes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_en | input | 1 | Parity check enable |
| recov_cycles | input | RCW (10) | Recovery length in cycles |
| crc_cycles | input | CCW (6) | CRC alert pulse width in cycles |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate command input |
| addr | input | AW (17) | Address / command inputs (top three bits double as command lines) |
| bg | input | BGW (2) | Bank group |
| ba | input | BAW (2) | Bank address |
| par_in | input | 1 | Parity bit for the command/address |
| crc_err | input | 1 | Write CRC error strobe |
| clr | input | 1 | Clear strobe for flag and capture |
| out_valid | output | 1 | Forwarded command valid |
| out_act_n | output | 1 | Forwarded activate input |
| out_addr | output | AW (17) | Forwarded address |
| out_bg | output | BGW (2) | Forwarded bank group |
| out_ba | output | BAW (2) | Forwarded bank address |
| alert_n | output | 1 | Active-low alert |
| err_flag | output | 1 | Sticky parity error flag |
| err_act_n | output | 1 | Captured activate input of failing command |
| err_addr | output | AW (17) | Captured address of failing command |
| err_bg | output | BGW (2) | Captured bank group of failing command |
| err_ba | output | BAW (2) | Captured bank address of failing command |

## Verification
The bench counts the exact length of the alert window for parity and CRC errors, including a zero length. This catches a counter that is off by one, or one that never ends. It sends a bad-parity command in the middle of recovery. A design that restarted the interval or re-captured the fields would show a longer alert or a changed error address. It runs a CRC pulse that is cut short by a parity error and then strobes `crc_err` during that recovery. A design that lets the CRC pulse survive, or re-arms it, would keep `alert_n` low after recovery has ended. A same-edge clear and error, commands with chip select high and bad parity, and the disabled mode cover flags that are lost, commands that are sampled when they should be ignored, and commands that are suppressed when checking is off.

// File: rtl/ca_parity_guard.sv
module ca_parity_guard #(
  parameter int AW  = 17,
  parameter int BGW = 2,
  parameter int BAW = 2,
  parameter int RCW = 10,
  parameter int CCW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_en,
  input  logic [RCW-1:0] recov_cycles,
  input  logic [CCW-1:0] crc_cycles,
  input  logic           cs_n,
  input  logic           act_n,
  input  logic [AW-1:0]  addr,
  input  logic [BGW-1:0] bg,
  input  logic [BAW-1:0] ba,
  input  logic           par_in,
  input  logic           crc_err,
  input  logic           clr,
  output logic           out_valid,
  output logic           out_act_n,
  output logic [AW-1:0]  out_addr,
  output logic [BGW-1:0] out_bg,
  output logic [BAW-1:0] out_ba,
  output logic           alert_n,
  output logic           err_flag,
  output logic           err_act_n,
  output logic [AW-1:0]  err_addr,
  output logic [BGW-1:0] err_bg,
  output logic [BAW-1:0] err_ba
);

  logic [RCW-1:0] rec_cnt;
  logic [CCW-1:0] crc_cnt;

  wire odd  = ^{act_n, addr, bg, ba, par_in};
  wire busy = |rec_cnt;
  wire hit  = !cs_n && par_en && odd && !busy;
  wire take = !cs_n && !busy && !(par_en && odd);

  wire [RCW-1:0] rec_load = (recov_cycles == '0) ? RCW'(1) : recov_cycles;
  wire [CCW-1:0] crc_load = (crc_cycles == '0) ? CCW'(1) : crc_cycles;

  assign alert_n = !(busy || (|crc_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rec_cnt <= '0;
    else if (hit)  rec_cnt <= rec_load;
    else if (busy) rec_cnt <= rec_cnt - RCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc_cnt <= '0;
    else if (hit)              crc_cnt <= '0;
    else if (crc_err && !busy) crc_cnt <= crc_load;
    else if (|crc_cnt)         crc_cnt <= crc_cnt - CCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_act_n <= 1'b1;
      out_addr  <= '0;
      out_bg    <= '0;
      out_ba    <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_act_n <= act_n;
        out_addr  <= addr;
        out_bg    <= bg;
        out_ba    <= ba;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_act_n <= 1'b0;
      err_addr  <= '0;
      err_bg    <= '0;
      err_ba    <= '0;
    end else if (hit && (!err_flag || clr)) begin
      err_flag  <= 1'b1;
      err_act_n <= act_n;
      err_addr  <= addr;
      err_bg    <= bg;
      err_ba    <= ba;
    end else if (clr) begin
      err_flag  <= 1'b0;
      err_act_n <= 1'b0;
      err_addr  <= '0;
      err_bg    <= '0;
      err_ba    <= '0;
    end
  end

  assert_drop_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && par_en && (^{act_n, addr, bg, ba, par_in}) && alert_n) |=> !out_valid);

  assert_alert_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && par_en && (^{act_n, addr, bg, ba, par_in}) && !busy) |=> (!alert_n && err_flag));

  assert_recovery_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_cnt > RCW'(1)) |=> !alert_n);

  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !out_valid);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_en && !cs_n && alert_n && !crc_err) |=> (out_valid && alert_n));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);

  assert_capture_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> ($stable(err_addr) && $stable(err_bg) && $stable(err_ba)));

endmodule

// File: tb/ca_parity_guard_tb.sv
`timescale 1ns/1ps
module ca_parity_guard_tb;
  localparam int AW = 17, BGW = 2, BAW = 2, RCW = 10, CCW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_en = 1'b1;
  logic [RCW-1:0] recov_cycles = RCW'(5);
  logic [CCW-1:0] crc_cycles = CCW'(3);
  logic cs_n = 1'b1, act_n = 1'b1, par_in = 1'b0, crc_err = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BGW-1:0] bg = '0;
  logic [BAW-1:0] ba = '0;
  logic out_valid, out_act_n, alert_n, err_flag, err_act_n;
  logic [AW-1:0] out_addr, err_addr;
  logic [BGW-1:0] out_bg, err_bg;
  logic [BAW-1:0] out_ba, err_ba;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ca_parity_guard #(.AW(AW), .BGW(BGW), .BAW(BAW), .RCW(RCW), .CCW(CCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .par_en(par_en), .recov_cycles(recov_cycles),
    .crc_cycles(crc_cycles), .cs_n(cs_n), .act_n(act_n), .addr(addr), .bg(bg),
    .ba(ba), .par_in(par_in), .crc_err(crc_err), .clr(clr),
    .out_valid(out_valid), .out_act_n(out_act_n), .out_addr(out_addr),
    .out_bg(out_bg), .out_ba(out_ba), .alert_n(alert_n), .err_flag(err_flag),
    .err_act_n(err_act_n), .err_addr(err_addr), .err_bg(err_bg), .err_ba(err_ba));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input bit sel, input bit a, input logic [AW-1:0] ad,
                       input logic [BGW-1:0] g, input logic [BAW-1:0] b, input bit good);
    cs_n   = !sel;
    act_n  = a;
    addr   = ad;
    bg     = g;
    ba     = b;
    par_in = (^{a, ad, g, b}) ^ !good;
  endtask

  task automatic idle();
    cs_n = 1'b1; crc_err = 1'b0; clr = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(alert_n === 1'b1, "R1 alert_n", alert_n, 1);
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    chk(err_flag === 1'b0, "R1 err_flag", err_flag, 0);
    chk(err_addr === '0, "R1 err_addr", err_addr, 0);
  endtask

  task automatic t_good();
    logic [AW-1:0] pats [4] = '{17'h00000, 17'h1FFFF, 17'h0A5A5, 17'h15A5A};
    for (int i = 0; i < 4; i++) begin
      drive(1, i[0], pats[i], BGW'(i), BAW'(3 - i), 1);
      step();
      chk(out_valid === 1'b1, "R2 good cmd valid", out_valid, 1);
      chk(out_addr === pats[i], "R2 addr forwarded", out_addr, pats[i]);
      chk(out_bg === BGW'(i) && out_ba === BAW'(3 - i), "R2 bank forwarded",
          {out_bg, out_ba}, {BGW'(i), BAW'(3 - i)});
      chk(out_act_n === i[0], "R2 act_n forwarded", out_act_n, i[0]);
      chk(alert_n === 1'b1, "R2 no alert on good", alert_n, 1);
    end
    drive(0, 0, 17'h00123, 2'd1, 2'd2, 0);
    step();
    chk(out_valid === 1'b0, "R2 cs_n high not sampled", out_valid, 0);
    chk(alert_n === 1'b1, "R2 cs_n high no alert", alert_n, 1);
    chk(err_flag === 1'b0, "R2 cs_n high no flag", err_flag, 0);
    idle();
  endtask

  task automatic t_disabled();
    par_en = 1'b0;
    drive(1, 1, 17'h0BEEF, 2'd3, 2'd1, 0);
    step();
    chk(out_valid === 1'b1, "R6 disabled forwards bad", out_valid, 1);
    chk(alert_n === 1'b1, "R6 disabled alert high", alert_n, 1);
    chk(err_flag === 1'b0, "R6 disabled no flag", err_flag, 0);
    idle();
    par_en = 1'b1;
    step();
  endtask

  task automatic t_parity();
    recov_cycles = RCW'(5);
    drive(1, 0, 17'h1C0DE, 2'd2, 2'd3, 0);
    step();
    chk(out_valid === 1'b0, "R3 bad cmd dropped", out_valid, 0);
    chk(alert_n === 1'b0, "R4 alert low after error", alert_n, 0);
    chk(err_flag === 1'b1, "R9 flag set", err_flag, 1);
    chk(err_addr === 17'h1C0DE && err_bg === 2'd2 && err_ba === 2'd3 && err_act_n === 1'b0,
        "R10 capture", err_addr, 17'h1C0DE);
    for (int i = 1; i <= 5; i++) begin
      if (i == 2) drive(1, 1, 17'h00777, 2'd1, 2'd1, 0);
      else        drive(1, 1, 17'h00042 + AW'(i), 2'd0, 2'd1, 1);
      step();
      chk(out_valid === 1'b0, "R5 dropped during recovery", out_valid, 0);
      chk(alert_n === (i == 5), "R4 recovery window length", alert_n, (i == 5));
    end
    chk(err_addr === 17'h1C0DE, "R5 no recapture in recovery", err_addr, 17'h1C0DE);
    drive(1, 1, 17'h00099, 2'd1, 2'd0, 1);
    step();
    chk(out_valid === 1'b1 && out_addr === 17'h00099, "R5 first cmd after recovery", out_addr, 17'h00099);
    drive(1, 1, 17'h03333, 2'd0, 2'd0, 0);
    step();
    chk(alert_n === 1'b0, "R4 second error alerts", alert_n, 0);
    chk(err_addr === 17'h1C0DE, "R10 no overwrite while flag set", err_addr, 17'h1C0DE);
    idle();
    repeat (5) step();
    chk(alert_n === 1'b1, "R4 alert released", alert_n, 1);
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk(err_flag === 1'b0, "R9 clear drops flag", err_flag, 0);
    chk(err_addr === '0, "R10 clear zeroes capture", err_addr, 0);
  endtask

  task automatic t_crc();
    crc_cycles = CCW'(3);
    crc_err = 1'b1;
    step();
    crc_err = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      chk(alert_n === (i == 4), "R7 crc pulse width", alert_n, (i == 4));
      step();
    end
    crc_err = 1'b1;
    step();
    crc_err = 1'b0;
    step();
    crc_err = 1'b1;
    step();
    crc_err = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      chk(alert_n === (i == 4), "R7 crc retrigger width", alert_n, (i == 4));
      step();
    end
    chk(err_flag === 1'b0, "R7 crc does not set flag", err_flag, 0);
  endtask

  task automatic t_override();
    crc_cycles = CCW'(6);
    recov_cycles = RCW'(2);
    crc_err = 1'b1;
    step();
    crc_err = 1'b0;
    chk(alert_n === 1'b0, "R7 crc alert", alert_n, 0);
    drive(1, 0, 17'h00AAA, 2'd1, 2'd2, 0);
    step();
    idle();
    chk(alert_n === 1'b0, "R8 parity during crc", alert_n, 0);
    crc_err = 1'b1;
    step();
    crc_err = 1'b0;
    chk(alert_n === 1'b0, "R8 recovery second cycle", alert_n, 0);
    step();
    chk(alert_n === 1'b1, "R8 crc cancelled and ignored", alert_n, 1);
    step();
    chk(alert_n === 1'b1, "R8 stays high", alert_n, 1);
  endtask

  task automatic t_clear_collide();
    chk(err_flag === 1'b1, "R9 flag before collide", err_flag, 1);
    clr = 1'b1;
    drive(1, 1, 17'h05555, 2'd3, 2'd3, 0);
    step();
    idle();
    chk(err_flag === 1'b1, "R9 error wins over clear", err_flag, 1);
    chk(err_addr === 17'h05555, "R10 recapture on clear+error", err_addr, 17'h05555);
    repeat (3) step();
  endtask

  task automatic t_zero_recov();
    recov_cycles = '0;
    drive(1, 0, 17'h00001, 2'd0, 2'd0, 0);
    step();
    idle();
    chk(alert_n === 1'b0, "R4 zero recovery one cycle low", alert_n, 0);
    step();
    chk(alert_n === 1'b1, "R4 zero recovery released", alert_n, 1);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step();
    t_reset();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_good();
    t_disabled();
    t_parity();
    t_crc();
    t_override();
    t_clear_collide();
    t_zero_recov();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule